// File: doc/BRIEF.md
# Virtual Interrupt Arbiter

This block decides which virtual interrupt a single processor interface should present next, and whether that interrupt may interrupt the code that is running now. It weighs two kinds of candidate. The first is a bank of list registers, each with a 2-bit state, a group bit and a priority. The second is a single interrupt that an external redistributor injects directly, given as a group and a priority. The block merges the two into one selected index: a list register number, a sentinel for the injected interrupt, or all ones when nothing qualifies. It then runs the preemption test against the priority mask and the highest active priority, and drives a virtual FIQ level for group 0 or a virtual IRQ level for group 1.

The block holds no architectural state of its own. Every cycle it recomputes its registered outputs from the current inputs. Writes to the list registers, enables, masks, active priority or security state therefore take effect one clock later. The surrounding logic reads the selected index to carry out acknowledge and highest-pending reads.

Top module: `virq_arbiter`

## Requirements
- R1: While reset is asserted, sel_idx reads 6'h3F and both virq and vfiq are 0.
- R2: A list register competes only when its state field equals 2'b01 (pending; 2'b00 idle, 2'b10 active, 2'b11 pending-and-active never compete), its priority is not 8'hFF, and the enable of its group is set (group bit 0 uses grp0_en, group bit 1 uses grp1_en).
- R3: Among competing list registers, the one with the numerically lowest priority wins, and a tie goes to the lowest index. The winner's index (0 to NUM_LR-1) appears on sel_idx.
- R4: When no list register competes and the injected interrupt does not win, sel_idx is 6'h3F (-1) and both levels are 0.
- R5: An injected priority of 8'hFF means no injected interrupt, and that value never wins.
- R6: The injected interrupt wins, and sel_idx reads 16, only if secure is 0, its group enable is set, and its priority is strictly lower than the best competing list-register priority. An equal priority leaves the list register selected.
- R7: With vif_en at 0, virq and vfiq stay 0 whatever is selected. The selection itself still appears on sel_idx.
- R8: A selected interrupt is not signalled when its priority is greater than or equal to pmask.
- R9: When active_prio is 8'hFF, a selected interrupt that is not masked is always signalled.
- R10: Otherwise it is signalled only if (prio & gmask) < (active_prio & gmask), where gmask is gmask0 for group 0 and gmask1 for group 1. Bits cleared in the mask (the subpriority) are ignored, and equal group priority does not preempt.
- R11: A signalled group 0 winner raises vfiq and a signalled group 1 winner raises virq. The rule is the same for list registers and the injected interrupt, and the two levels are never high together.
- R12: Outputs are registered. The result reflects the inputs present at the previous rising edge, so a change of secure alone re-evaluates whether the injected interrupt is eligible, one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_state | input | 2*NUM_LR | State of each list register, 2 bits per entry, entry i at [2i+1:2i] |
| lr_group | input | NUM_LR | Group bit of each list register |
| lr_prio | input | NUM_LR*PRIO_W | Priority of each list register, entry i at [PRIO_W*i +: PRIO_W] |
| inj_group | input | 1 | Group of the injected interrupt |
| inj_prio | input | PRIO_W | Priority of the injected interrupt, all ones when none |
| secure | input | 1 | Processor is in secure state |
| vif_en | input | 1 | Virtual interface enable |
| grp0_en | input | 1 | Virtual group 0 enable |
| grp1_en | input | 1 | Virtual group 1 enable |
| pmask | input | PRIO_W | Virtual priority mask |
| gmask0 | input | PRIO_W | Group-priority mask for group 0 |
| gmask1 | input | PRIO_W | Group-priority mask for group 1 |
| active_prio | input | PRIO_W | Highest active priority, all ones when nothing runs |
| sel_idx | output | 6 | Selected index: 0..NUM_LR-1, 16 for injected, 6'h3F for none |
| virq | output | 1 | Virtual IRQ level |
| vfiq | output | 1 | Virtual FIQ level |

## Verification
sel_idx, virq and vfiq are each due exactly one rising edge after the inputs that produce them. No result needs more than one cycle. The driver applies a new input set on a falling edge and queues the expected result at that moment. The monitor compares shortly after the next rising edge and pops only items that were queued before that edge, so each comparison lines up with the single register stage. Changing secure alone is checked the same way: its effect on the injected candidate shows up in the next compared item.

// File: rtl/virq_arb_pkg.sv
package virq_arb_pkg;
    localparam int SEL_W = 6;
    localparam int LR_MAX = 16;
    localparam logic [SEL_W-1:0] SEL_NONE = '1;
    localparam logic [SEL_W-1:0] SEL_INJ = SEL_W'(LR_MAX);
    localparam logic [1:0] LR_ST_PENDING = 2'b01;

    typedef struct packed {
        logic [SEL_W-1:0] idx;
        logic             virq;
        logic             vfiq;
    } arb_out_t;
endpackage

// File: rtl/virq_lr_pick.sv
module virq_lr_pick
    import virq_arb_pkg::*;
#(
    parameter int NUM_LR = 16,
    parameter int PRIO_W = 8
) (
    input  logic [2*NUM_LR-1:0]      lr_state,
    input  logic [NUM_LR-1:0]        lr_group,
    input  logic [NUM_LR*PRIO_W-1:0] lr_prio,
    input  logic                     grp0_en,
    input  logic                     grp1_en,
    output logic                     found,
    output logic [SEL_W-1:0]         idx,
    output logic [PRIO_W-1:0]        prio,
    output logic                     grp
);
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    logic [PRIO_W-1:0] prio_lane [NUM_LR];
    logic [NUM_LR-1:0] elig;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_lane
        assign prio_lane[g] = lr_prio[g*PRIO_W +: PRIO_W];
        assign elig[g] = (lr_state[2*g +: 2] == LR_ST_PENDING)
                      && (prio_lane[g] != PRIO_IDLE)
                      && (lr_group[g] ? grp1_en : grp0_en);
    end

    always_comb begin
        found = 1'b0;
        idx   = SEL_NONE;
        prio  = PRIO_IDLE;
        grp   = 1'b0;
        for (int i = 0; i < NUM_LR; i++) begin
            // strict compare keeps the lowest index on equal priority
            if (elig[i] && (prio_lane[i] < prio)) begin
                found = 1'b1;
                idx   = SEL_W'(i);
                prio  = prio_lane[i];
                grp   = lr_group[i];
            end
        end
    end
endmodule

// File: rtl/virq_inj_gate.sv
module virq_inj_gate #(
    parameter int PRIO_W = 8
) (
    input  logic              secure,
    input  logic              inj_group,
    input  logic [PRIO_W-1:0] inj_prio,
    input  logic              grp0_en,
    input  logic              grp1_en,
    input  logic [PRIO_W-1:0] best_lr_prio,
    output logic              inj_win
);
    // an idle injected priority (all ones) can never be strictly below best_lr_prio
    always_comb begin
        inj_win = !secure
               && (inj_prio < best_lr_prio)
               && (inj_group ? grp1_en : grp0_en);
    end
endmodule

// File: rtl/virq_preempt.sv
module virq_preempt #(
    parameter int PRIO_W = 8
) (
    input  logic              vif_en,
    input  logic [PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0] pmask,
    input  logic [PRIO_W-1:0] gmask,
    input  logic [PRIO_W-1:0] active_prio,
    output logic              can_fire
);
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    always_comb begin
        if (!vif_en || (prio >= pmask)) begin
            can_fire = 1'b0;
        end else if (active_prio == PRIO_IDLE) begin
            can_fire = 1'b1;
        end else begin
            can_fire = (prio & gmask) < (active_prio & gmask);
        end
    end
endmodule

// File: rtl/virq_arbiter.sv
module virq_arbiter
    import virq_arb_pkg::*;
#(
    parameter int NUM_LR = 16,
    parameter int PRIO_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*NUM_LR-1:0]      lr_state,
    input  logic [NUM_LR-1:0]        lr_group,
    input  logic [NUM_LR*PRIO_W-1:0] lr_prio,
    input  logic                     inj_group,
    input  logic [PRIO_W-1:0]        inj_prio,
    input  logic                     secure,
    input  logic                     vif_en,
    input  logic                     grp0_en,
    input  logic                     grp1_en,
    input  logic [PRIO_W-1:0]        pmask,
    input  logic [PRIO_W-1:0]        gmask0,
    input  logic [PRIO_W-1:0]        gmask1,
    input  logic [PRIO_W-1:0]        active_prio,
    output logic [5:0]               sel_idx,
    output logic                     virq,
    output logic                     vfiq
);
    logic              lr_found;
    logic [SEL_W-1:0]  lr_idx;
    logic [PRIO_W-1:0] lr_best_prio;
    logic              lr_best_grp;
    logic              inj_win;
    logic [PRIO_W-1:0] cand_prio;
    logic              cand_grp;
    logic [PRIO_W-1:0] cand_gmask;
    logic              cand_fire;
    arb_out_t          out_d;
    arb_out_t          out_q;

    virq_lr_pick #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_pick (
        .lr_state (lr_state),
        .lr_group (lr_group),
        .lr_prio  (lr_prio),
        .grp0_en  (grp0_en),
        .grp1_en  (grp1_en),
        .found    (lr_found),
        .idx      (lr_idx),
        .prio     (lr_best_prio),
        .grp      (lr_best_grp)
    );

    virq_inj_gate #(.PRIO_W(PRIO_W)) u_inj (
        .secure       (secure),
        .inj_group    (inj_group),
        .inj_prio     (inj_prio),
        .grp0_en      (grp0_en),
        .grp1_en      (grp1_en),
        .best_lr_prio (lr_best_prio),
        .inj_win      (inj_win)
    );

    assign cand_prio  = inj_win ? inj_prio : lr_best_prio;
    assign cand_grp   = inj_win ? inj_group : lr_best_grp;
    assign cand_gmask = cand_grp ? gmask1 : gmask0;

    virq_preempt #(.PRIO_W(PRIO_W)) u_pre (
        .vif_en      (vif_en),
        .prio        (cand_prio),
        .pmask       (pmask),
        .gmask       (cand_gmask),
        .active_prio (active_prio),
        .can_fire    (cand_fire)
    );

    always_comb begin
        out_d = '0;
        if (inj_win) begin
            out_d.idx = SEL_INJ;
        end else begin
            out_d.idx = lr_idx;
        end
        if ((inj_win || lr_found) && cand_fire) begin
            out_d.vfiq = !cand_grp;
            out_d.virq = cand_grp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{idx: SEL_NONE, virq: 1'b0, vfiq: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign sel_idx = out_q.idx;
    assign virq    = out_q.virq;
    assign vfiq    = out_q.vfiq;
endmodule

// File: rtl/virq_arbiter_chk.sv
module virq_arbiter_chk
    import virq_arb_pkg::*;
#(
    parameter int NUM_LR = 16,
    parameter int PRIO_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_LR-1:0] lr_state,
    input logic [PRIO_W-1:0]   inj_prio,
    input logic                secure,
    input logic                vif_en,
    input logic [5:0]          sel_idx,
    input logic                virq,
    input logic                vfiq
);
    logic [NUM_LR-1:0] pend;
    for (genvar g = 0; g < NUM_LR; g++) begin : g_pend
        assign pend[g] = (lr_state[2*g +: 2] == LR_ST_PENDING);
    end

    a_r11_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({virq, vfiq}));

    a_r12_secure_no_inj: assert property (@(posedge clk) disable iff (!rst_n)
        secure |=> (sel_idx != SEL_INJ));

    a_r5_idle_inj_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_prio == '1) |=> (sel_idx != SEL_INJ));

    a_r7_iface_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vif_en |=> !(virq || vfiq));

    a_r4_nothing_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend == '0) && (secure || (inj_prio == '1))) |=>
            ((sel_idx == SEL_NONE) && !virq && !vfiq));

    a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_idx == SEL_NONE) || (sel_idx == SEL_INJ) || (sel_idx < SEL_W'(NUM_LR)));
endmodule

bind virq_arbiter virq_arbiter_chk #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lr_state (lr_state),
    .inj_prio (inj_prio),
    .secure   (secure),
    .vif_en   (vif_en),
    .sel_idx  (sel_idx),
    .virq     (virq),
    .vfiq     (vfiq)
);

// File: tb/virq_arbiter_bench.sv
module virq_arbiter_bench;
    localparam int NL = 16;
    localparam int PW = 8;

    typedef struct {
        logic [5:0] idx;
        logic       irq;
        logic       fiq;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [2*NL-1:0]  lr_state = '0;
    logic [NL-1:0]    lr_group = '0;
    logic [NL*PW-1:0] lr_prio = '1;
    logic             inj_group = 1'b0;
    logic [PW-1:0]    inj_prio = '1;
    logic             secure = 1'b0;
    logic             vif_en = 1'b1;
    logic             grp0_en = 1'b1;
    logic             grp1_en = 1'b1;
    logic [PW-1:0]    pmask = '1;
    logic [PW-1:0]    gmask0 = '1;
    logic [PW-1:0]    gmask1 = '1;
    logic [PW-1:0]    active_prio = '1;
    logic [5:0]       sel_idx;
    logic             virq;
    logic             vfiq;

    // staged stimulus, copied to the pins by the driver
    logic [2*NL-1:0]  s_state = '0;
    logic [NL-1:0]    s_group = '0;
    logic [NL*PW-1:0] s_prio = '1;
    logic             s_igrp = 1'b0;
    logic [PW-1:0]    s_iprio = '1;
    logic             s_sec = 1'b0;
    logic             s_vif = 1'b1;
    logic             s_g0 = 1'b1;
    logic             s_g1 = 1'b1;
    logic [PW-1:0]    s_pm = '1;
    logic [PW-1:0]    s_gm0 = '1;
    logic [PW-1:0]    s_gm1 = '1;
    logic [PW-1:0]    s_act = '1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    virq_arbiter #(.NUM_LR(NL), .PRIO_W(PW)) u_virq_arbiter (
        .clk(clk), .rst_n(rst_n), .lr_state(lr_state), .lr_group(lr_group),
        .lr_prio(lr_prio), .inj_group(inj_group), .inj_prio(inj_prio),
        .secure(secure), .vif_en(vif_en), .grp0_en(grp0_en), .grp1_en(grp1_en),
        .pmask(pmask), .gmask0(gmask0), .gmask1(gmask1),
        .active_prio(active_prio), .sel_idx(sel_idx), .virq(virq), .vfiq(vfiq)
    );

    task automatic set_lr(int i, logic [1:0] st, logic g, logic [7:0] p);
        s_state[2*i +: 2] = st;
        s_group[i] = g;
        s_prio[PW*i +: PW] = p;
    endtask

    task automatic clear_lrs();
        s_state = '0;
        s_group = '0;
        s_prio = '1;
    endtask

    task automatic apply();
        @(negedge clk);
        lr_state = s_state; lr_group = s_group; lr_prio = s_prio;
        inj_group = s_igrp; inj_prio = s_iprio; secure = s_sec;
        vif_en = s_vif; grp0_en = s_g0; grp1_en = s_g1; pmask = s_pm;
        gmask0 = s_gm0; gmask1 = s_gm1; active_prio = s_act;
    endtask

    // hand-computed expectation
    task automatic drive(string tag, logic [5:0] e_idx, logic e_irq, logic e_fiq);
        exp_t e;
        apply();
        e.idx = e_idx; e.irq = e_irq; e.fiq = e_fiq; e.tag = tag;
        q.push_back(e);
    endtask

    // requirement model used for the sweep
    function automatic exp_t model();
        exp_t e;
        logic [7:0] bp;
        logic [7:0] cp;
        logic [7:0] gm;
        logic bg;
        logic cg;
        logic ok;
        bit found;
        int bi;
        found = 0; bi = -1; bp = 8'hFF; bg = 0;
        for (int i = 0; i < NL; i++) begin
            logic [7:0] p;
            p = s_prio[PW*i +: PW];
            if (s_state[2*i +: 2] == 2'b01 && p != 8'hFF
                && (s_group[i] ? s_g1 : s_g0) && p < bp) begin
                found = 1; bi = i; bp = p; bg = s_group[i];
            end
        end
        e.tag = "R3 R6 R10 sweep";
        if (!s_sec && s_iprio < bp && (s_igrp ? s_g1 : s_g0)) begin
            e.idx = 6'd16; cp = s_iprio; cg = s_igrp; found = 1;
        end else begin
            e.idx = found ? 6'(bi) : 6'h3F; cp = bp; cg = bg;
        end
        gm = cg ? s_gm1 : s_gm0;
        if (!s_vif || cp >= s_pm) ok = 0;
        else if (s_act == 8'hFF) ok = 1;
        else ok = (cp & gm) < (s_act & gm);
        e.irq = found && ok && cg;
        e.fiq = found && ok && !cg;
        return e;
    endfunction

    task automatic drive_model();
        exp_t e;
        apply();
        e = model();
        q.push_back(e);
    endtask

    // monitor: compares one edge after each queued item
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (sel_idx !== e.idx || virq !== e.irq || vfiq !== e.fiq) begin
                    errors++;
                    $display("FAIL %s: got idx=%0d irq=%0b fiq=%0b, expected idx=%0d irq=%0b fiq=%0b",
                             e.tag, sel_idx, virq, vfiq, e.idx, e.irq, e.fiq);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #22;
        checks++;
        if (sel_idx !== 6'h3F || virq !== 1'b0 || vfiq !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got idx=%0d irq=%0b fiq=%0b, expected idx=63 irq=0 fiq=0",
                     sel_idx, virq, vfiq);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive("R4 idle", 6'h3F, 0, 0);
        set_lr(3, 2'b01, 1, 8'h40);
        drive("R3 single LR", 6'd3, 1, 0);
        set_lr(5, 2'b01, 0, 8'h30);
        set_lr(2, 2'b01, 1, 8'h30);
        drive("R3 tie lowest index", 6'd2, 1, 0);
        set_lr(2, 2'b11, 1, 8'h30);
        drive("R2 pending-active skipped", 6'd5, 0, 1);
        s_g0 = 0;
        drive("R2 group disabled", 6'd3, 1, 0);
        s_g0 = 1;
        clear_lrs();
        set_lr(2, 2'b01, 1, 8'hFF);
        set_lr(5, 2'b10, 0, 8'h10);
        drive("R2 idle prio and active state", 6'h3F, 0, 0);
        set_lr(4, 2'b01, 1, 8'h50);
        drive("R2 R3 LR4", 6'd4, 1, 0);
        s_igrp = 0; s_iprio = 8'h20;
        drive("R6 injected wins", 6'd16, 0, 1);
        s_iprio = 8'h50;
        drive("R6 equal prio keeps LR", 6'd4, 1, 0);
        s_iprio = 8'h20; s_sec = 1;
        drive("R12 secure hides injected", 6'd4, 1, 0);
        s_sec = 0;
        drive("R12 leaving secure", 6'd16, 0, 1);
        s_g0 = 0;
        drive("R6 group0 enable off", 6'd4, 1, 0);
        s_g0 = 1;
        clear_lrs();
        s_iprio = 8'hFF;
        drive("R5 idle injected", 6'h3F, 0, 0);
        s_igrp = 1; s_iprio = 8'h20; s_vif = 0;
        drive("R7 interface off", 6'd16, 0, 0);
        s_vif = 1;
        drive("R7 interface on", 6'd16, 1, 0);
        s_pm = 8'h20;
        drive("R8 prio equals mask", 6'd16, 0, 0);
        s_pm = 8'h21;
        drive("R8 prio below mask", 6'd16, 1, 0);
        s_pm = 8'hFF; s_act = 8'h48; s_gm1 = 8'hF0; s_iprio = 8'h44;
        drive("R10 subpriority ignored", 6'd16, 0, 0);
        s_iprio = 8'h38;
        drive("R10 higher group prio", 6'd16, 1, 0);
        s_gm1 = 8'hFF; s_iprio = 8'h44;
        drive("R10 full mask", 6'd16, 1, 0);
        s_iprio = 8'h48;
        drive("R10 equal does not preempt", 6'd16, 0, 0);
        s_gm0 = 8'hF0; s_iprio = 8'h44; s_igrp = 0;
        drive("R10 R11 group0 mask", 6'd16, 0, 0);
        s_igrp = 1;
        drive("R10 R11 group1 mask", 6'd16, 1, 0);
        s_act = 8'hFF; s_igrp = 0; s_iprio = 8'hFE;
        drive("R9 nothing active", 6'd16, 0, 1);
        s_iprio = 8'hFF;
        set_lr(0, 2'b01, 0, 8'h10);
        drive("R11 LR group0 to fiq", 6'd0, 0, 1);

        for (int n = 0; n < 400; n++) begin
            clear_lrs();
            for (int i = 0; i < NL; i++) begin
                if ($urandom_range(0, 2) == 0)
                    set_lr(i, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                           8'($urandom_range(0, 7) * 32 + $urandom_range(0, 1) * 31));
            end
            s_igrp = 1'($urandom_range(0, 1));
            s_iprio = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
            s_sec = ($urandom_range(0, 3) == 0);
            s_vif = ($urandom_range(0, 7) != 0);
            s_g0 = ($urandom_range(0, 5) != 0);
            s_g1 = ($urandom_range(0, 5) != 0);
            s_pm = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
            s_gm0 = 8'hFF << $urandom_range(0, 7);
            s_gm1 = 8'hFF << $urandom_range(0, 7);
            s_act = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
            drive_model();
        end

        repeat (4) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule